// File: doc/BRIEF.md
# Sign-Magnitude Adder with End-Around Carry

This block adds two signed numbers held as a magnitude plus a separate sign bit and returns the sum in the same form. When the two signs agree, the magnitudes are simply added. A carry out of the top magnitude bit is then flagged on its own output. When the signs differ, only operand B's magnitude is inverted. The carry out of the top bit is fed back into the low end as an end-around carry. If that carry is clear, the sum bits are inverted. The returned magnitude is therefore never negative, and no comparator or second subtraction is needed.

All carries come from a single Kogge-Stone parallel prefix pass over generate/propagate pairs. The end-around carry is applied to the prefix outputs as `G[i-1:0] | (P[i-1:0] & cout)`, so a second increment pass is avoided. The magnitude width is a parameter, and it defaults to 129 bits. A parameter also chooses between a registered output stage with synchronous active-high reset and a purely combinational output.

Top module: `eac_adder`

## Requirements
- R1: When `a_sign == b_sign`, `sum_mag` equals the low W bits of `a_mag + b_mag`.
- R2: When `a_sign != b_sign`, `sum_mag` equals the absolute difference of `a_mag` and `b_mag`.
- R3: `sum_sign` equals `a_sign` when the signs agree. When the signs differ, it is the sign of the operand with the larger magnitude. A sign bit of 1 means negative.
- R4: `ovf` is 1 exactly when the signs agree and `a_mag + b_mag` does not fit in W bits. When the signs differ, `ovf` is always 0.
- R5: Operands of equal magnitude and opposite sign give `sum_mag` of zero.
- R6: A zero result from operands of differing sign always has `sum_sign` 0.
- R7: With `REG_OUT=1`, the outputs reflect the inputs sampled at the previous rising clock edge and do not follow input changes between edges. With `REG_OUT=0`, the outputs follow the inputs combinationally.
- R8: With `REG_OUT=1`, a synchronous `rst` high clears `sum_mag` to zero and clears `sum_sign` and `ovf` to 0, whatever the inputs are.
- R9: The behaviour of R1 to R6 holds for magnitude widths that are not powers of two, including very narrow ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_mag | input | W | Magnitude of operand A |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| b_mag | input | W | Magnitude of operand B |
| b_sign | input | 1 | Sign of operand B (1 = negative) |
| sum_mag | output | W | Non-negative magnitude of the sum |
| sum_sign | output | 1 | Sign of the sum |
| ovf | output | 1 | Magnitude carry out on effective addition |

## Verification
The bench builds two copies of the adder.

- **129-bit copy, registered output.** It takes the corner operands (zeros, all-ones, equal magnitudes, negative zero, off-by-one) and random operands. Some of the random pairs share most of their upper bits, which drives carries through the full eight-level prefix tree. This copy also exposes the reset behaviour and the one-cycle output latency.
- **6-bit copy, combinational output.** This width is not a power of two and leaves the top prefix level partly filled. The copy is swept over every pair of magnitudes with all four sign combinations. Every end-around-carry case is therefore reached, including each tie and each overflow.

// File: rtl/eac_pkg.sv
package eac_pkg;

  // Effective operation chosen from the operand signs
  typedef enum logic {
    EAC_ADD = 1'b0,
    EAC_SUB = 1'b1
  } eac_op_e;

  // Number of Kogge-Stone levels needed to span w bits
  function automatic int ks_depth(input int w);
    int d;
    d = 0;
    while ((1 << d) < w) d++;
    return d;
  endfunction

endpackage

// File: rtl/eac_precond.sv
module eac_precond
  import eac_pkg::*;
#(
  parameter int W = 129
) (
  input  logic [W-1:0] a_mag,
  input  logic         a_sign,
  input  logic [W-1:0] b_mag,
  input  logic         b_sign,
  output eac_op_e      op,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);

  logic [W-1:0] b_eff;

  // Only operand B is ever complemented
  always_comb begin
    op    = (a_sign ^ b_sign) ? EAC_SUB : EAC_ADD;
    b_eff = (op == EAC_SUB) ? ~b_mag : b_mag;
    prop  = a_mag ^ b_eff;
    gen   = a_mag & b_eff;
  end

endmodule

// File: rtl/eac_ks_tree.sv
module eac_ks_tree
  import eac_pkg::*;
#(
  parameter int W = 129
) (
  input  logic [W-1:0] prop,
  input  logic [W-1:0] gen,
  output logic [W-1:0] grp_g,   // G[i:0]
  output logic [W-1:0] grp_p    // P[i:0]
);

  localparam int DEPTH = ks_depth(W);

  logic [DEPTH:0][W-1:0] lvl_g;
  logic [DEPTH:0][W-1:0] lvl_p;

  // Level k combines each bit with the one 2**k places below it
  always_comb begin
    lvl_g[0] = gen;
    lvl_p[0] = prop;
    for (int k = 0; k < DEPTH; k++) begin
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << k)) begin
          lvl_g[k+1][i] = lvl_g[k][i] | (lvl_p[k][i] & lvl_g[k][i-(1<<k)]);
          lvl_p[k+1][i] = lvl_p[k][i] & lvl_p[k][i-(1<<k)];
        end else begin
          lvl_g[k+1][i] = lvl_g[k][i];
          lvl_p[k+1][i] = lvl_p[k][i];
        end
      end
    end
  end

  assign grp_g = lvl_g[DEPTH];
  assign grp_p = lvl_p[DEPTH];

endmodule

// File: rtl/eac_fixup.sv
module eac_fixup
  import eac_pkg::*;
#(
  parameter int W = 129
) (
  input  eac_op_e      op,
  input  logic [W-1:0] prop,
  input  logic [W-1:0] grp_g,
  input  logic [W-1:0] grp_p,
  input  logic         a_sign,
  input  logic         b_sign,
  output logic [W-1:0] mag,
  output logic         sign,
  output logic         ovf
);

  logic         cout;
  logic         wrap_cin;
  logic [W-1:0] carry;
  logic [W-1:0] raw_sum;
  logic         b_larger;
  logic         is_zero;

  always_comb begin
    cout     = grp_g[W-1];
    wrap_cin = (op == EAC_SUB) & cout;
    // End-around carry folded into the prefix results
    carry[0] = wrap_cin;
    for (int i = 1; i < W; i++) begin
      carry[i] = grp_g[i-1] | (grp_p[i-1] & wrap_cin);
    end
    raw_sum  = prop ^ carry;
    // No carry out on subtraction: B is larger, result is ~(A + ~B)
    b_larger = (op == EAC_SUB) & ~cout;
    mag      = b_larger ? ~raw_sum : raw_sum;
    is_zero  = ~|mag;
    if (op == EAC_ADD) begin
      sign = a_sign;
    end else begin
      sign = (b_larger ? b_sign : a_sign) & ~is_zero;
    end
    ovf = (op == EAC_ADD) & cout;
  end

endmodule

// File: rtl/eac_adder.sv
module eac_adder
  import eac_pkg::*;
#(
  parameter int W       = 129,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_mag,
  input  logic         a_sign,
  input  logic [W-1:0] b_mag,
  input  logic         b_sign,
  output logic [W-1:0] sum_mag,
  output logic         sum_sign,
  output logic         ovf
);

  eac_op_e      op;
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W-1:0] grp_g;
  logic [W-1:0] grp_p;
  logic [W-1:0] comb_mag;
  logic         comb_sign;
  logic         comb_ovf;

  eac_precond #(.W(W)) u_precond (
    .a_mag (a_mag),
    .a_sign(a_sign),
    .b_mag (b_mag),
    .b_sign(b_sign),
    .op    (op),
    .prop  (prop),
    .gen   (gen)
  );

  eac_ks_tree #(.W(W)) u_tree (
    .prop (prop),
    .gen  (gen),
    .grp_g(grp_g),
    .grp_p(grp_p)
  );

  eac_fixup #(.W(W)) u_fixup (
    .op    (op),
    .prop  (prop),
    .grp_g (grp_g),
    .grp_p (grp_p),
    .a_sign(a_sign),
    .b_sign(b_sign),
    .mag   (comb_mag),
    .sign  (comb_sign),
    .ovf   (comb_ovf)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          sum_mag  <= '0;
          sum_sign <= 1'b0;
          ovf      <= 1'b0;
        end else begin
          sum_mag  <= comb_mag;
          sum_sign <= comb_sign;
          ovf      <= comb_ovf;
        end
      end
    end else begin : g_comb
      assign sum_mag  = comb_mag;
      assign sum_sign = comb_sign;
      assign ovf      = comb_ovf;
    end
  endgenerate

endmodule

// File: rtl/eac_adder_chk.sv
module eac_adder_chk #(
  parameter int W = 129
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_mag,
  input logic         a_sign,
  input logic [W-1:0] b_mag,
  input logic         b_sign,
  input logic [W-1:0] comb_mag,
  input logic         comb_sign,
  input logic         comb_ovf
);

  logic [W-1:0] larger_mag;
  assign larger_mag = (a_mag > b_mag) ? a_mag : b_mag;

  AST_ADD_SIGN_FROM_A: assert property (@(posedge clk) disable iff (rst)
    (a_sign == b_sign) |-> (comb_sign == a_sign)); // R3
  AST_SUB_SIGN_OF_LARGER: assert property (@(posedge clk) disable iff (rst)
    ((a_sign != b_sign) && (a_mag > b_mag)) |-> (comb_sign == a_sign)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (a_sign != b_sign) |-> !comb_ovf); // R4
  AST_SUB_MAG_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (a_sign != b_sign) |-> (comb_mag <= larger_mag)); // R2
  AST_TIE_CANCELS: assert property (@(posedge clk) disable iff (rst)
    ((a_sign != b_sign) && (a_mag == b_mag)) |-> (comb_mag == '0)); // R5
  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    ((a_sign != b_sign) && (comb_mag == '0)) |-> !comb_sign); // R6

endmodule

bind eac_adder eac_adder_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_mag    (a_mag),
  .a_sign   (a_sign),
  .b_mag    (b_mag),
  .b_sign   (b_sign),
  .comb_mag (comb_mag),
  .comb_sign(comb_sign),
  .comb_ovf (comb_ovf)
);

// File: tb/eac_adder_bench.sv
module eac_adder_bench;

  localparam int WL = 129;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [WL-1:0] a_l, b_l, m_l;
  logic          sa_l, sb_l, s_l, o_l;
  logic [WS-1:0] a_s, b_s, m_s;
  logic          sa_s, sb_s, s_s, o_s;

  eac_adder #(.W(WL), .REG_OUT(1'b1)) u_eac_adder (
    .clk(clk), .rst(rst), .a_mag(a_l), .a_sign(sa_l), .b_mag(b_l), .b_sign(sb_l),
    .sum_mag(m_l), .sum_sign(s_l), .ovf(o_l));

  eac_adder #(.W(WS), .REG_OUT(1'b0)) u_eac_adder_w6 (
    .clk(clk), .rst(rst), .a_mag(a_s), .a_sign(sa_s), .b_mag(b_s), .b_sign(sb_s),
    .sum_mag(m_s), .sum_sign(s_s), .ovf(o_s));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected values for the registered copy, one entry per driven cycle
  logic [WL-1:0] qm[$];
  logic          qs[$];
  logic          qo[$];
  string         qtm[$];
  string         qts[$];

  logic [WL-1:0] held_m;
  logic          held_s, held_o, held_valid;
  logic [WL-1:0] es_m;
  logic          es_s, es_o, es_valid;
  string         es_tm, es_ts;

  task automatic chk(input string req, input string what,
                     input logic [WL-1:0] act, input logic [WL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: integer add or compare-and-subtract
  function automatic void model(input logic [WL-1:0] a, input logic [WL-1:0] b,
                                input logic sa, input logic sb, input int w,
                                output logic [WL-1:0] m, output logic s, output logic o);
    logic [WL:0]   full;
    logic [WL-1:0] mask;
    mask = '1;
    mask = mask >> (WL - w);
    if (sa == sb) begin
      full = {1'b0, a} + {1'b0, b};
      m = full[WL-1:0] & mask;
      o = full[w];
      s = sa;
    end else begin
      o = 1'b0;
      if (a >= b) begin
        m = a - b;
        s = (a == b) ? 1'b0 : sa;
      end else begin
        m = b - a;
        s = sb;
      end
    end
  endfunction

  function automatic string mag_tag(input logic sa, input logic sb, input logic eq);
    if (sa == sb) return "R1";
    if (eq) return "R5";
    return "R2";
  endfunction

  function automatic string sign_tag(input logic sa, input logic sb, input logic zero);
    if ((sa != sb) && zero) return "R6";
    return "R3";
  endfunction

  task automatic apply(input logic [WL-1:0] al, input logic [WL-1:0] bl,
                       input logic sal, input logic sbl,
                       input logic [WS-1:0] as_, input logic [WS-1:0] bs_,
                       input logic sas, input logic sbs);
    logic [WL-1:0] em;
    logic          es, eo;
    @(negedge clk);
    held_valid = 1'b0;
    if (qm.size() > 0) begin
      held_m = qm.pop_front();
      held_s = qs.pop_front();
      held_o = qo.pop_front();
      chk(qtm.pop_front(), "mag", m_l, held_m);
      chk(qts.pop_front(), "sign", {{(WL-1){1'b0}}, s_l}, {{(WL-1){1'b0}}, held_s});
      chk("R4", "ovf", {{(WL-1){1'b0}}, o_l}, {{(WL-1){1'b0}}, held_o});
      held_valid = 1'b1;
    end
    if (es_valid) begin
      chk({"R9 ", es_tm}, "w6 mag", {{(WL-WS){1'b0}}, m_s}, es_m);
      chk({"R9 ", es_ts}, "w6 sign", {{(WL-1){1'b0}}, s_s}, {{(WL-1){1'b0}}, es_s});
      chk("R9 R4", "w6 ovf", {{(WL-1){1'b0}}, o_s}, {{(WL-1){1'b0}}, es_o});
    end
    a_l = al; b_l = bl; sa_l = sal; sb_l = sbl;
    a_s = as_; b_s = bs_; sa_s = sas; sb_s = sbs;
    model(al, bl, sal, sbl, WL, em, es, eo);
    qm.push_back(em); qs.push_back(es); qo.push_back(eo);
    qtm.push_back(mag_tag(sal, sbl, al == bl));
    qts.push_back(sign_tag(sal, sbl, em == '0));
    model({{(WL-WS){1'b0}}, as_}, {{(WL-WS){1'b0}}, bs_}, sas, sbs, WS, es_m, es_s, es_o);
    es_tm = mag_tag(sas, sbs, as_ == bs_);
    es_ts = sign_tag(sas, sbs, es_m == '0);
    es_valid = 1'b1;
    #1;
    if (held_valid) begin
      // registered copy must not follow the new inputs before the edge
      chk("R7", "held mag", m_l, held_m);
    end
  endtask

  function automatic logic [WL-1:0] rnd();
    logic [159:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return t[WL-1:0];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WL-1:0] ones, x, y;
    ones = '1;
    es_valid = 1'b0;
    held_valid = 1'b0;
    // inputs busy during reset: reset must win
    a_l = ones; b_l = ones; sa_l = 1'b1; sb_l = 1'b1;
    a_s = '0; b_s = '0; sa_s = 1'b0; sb_s = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "reset mag", m_l, '0);
    chk("R8", "reset sign", {{(WL-1){1'b0}}, s_l}, '0);
    chk("R8", "reset ovf", {{(WL-1){1'b0}}, o_l}, '0);
    rst = 1'b0;

    // corner operands on the wide copy
    apply('0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    apply('0, '0, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0);      // negative zero on addition
    apply('0, '0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    apply(ones, ones, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);  // overflow
    apply(ones, ones, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);  // tie
    apply(ones, ones, 1'b0, 1'b1, '0, '0, 1'b0, 1'b0);
    apply(ones, '0, 1'b0, 1'b1, '0, '0, 1'b0, 1'b0);
    apply('0, ones, 1'b0, 1'b1, '0, '0, 1'b0, 1'b0);
    apply(ones, 1, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0);     // carry through all bits
    apply(ones - 1, ones, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    apply(ones, ones - 1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
    apply({1'b1, {(WL-1){1'b0}}}, 1, 1'b0, 1'b1, '0, '0, 1'b0, 1'b0);

    // exhaustive narrow copy, random wide operands alongside
    for (int ia = 0; ia < (1 << WS); ia++) begin
      for (int ib = 0; ib < (1 << WS); ib++) begin
        for (int sg = 0; sg < 4; sg++) begin
          x = rnd();
          case ($urandom % 4)
            0: y = x;
            1: y = x ^ (rnd() >> 100);
            2: y = ~x;
            default: y = rnd();
          endcase
          apply(x, y, $urandom % 2 == 1, $urandom % 2 == 1,
                ia[WS-1:0], ib[WS-1:0], sg[1], sg[0]);
        end
      end
    end
    apply('0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    apply('0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule